// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

A synthesizable SPI mode-0 target that behaves like a small serial EEPROM. A host drives a frame by pulling chip select low, shifting an instruction byte, optionally an address and data, and raising chip select again. The storage is an on-chip byte array. A status byte holds a busy flag, a write-enable latch, two protection bits and a protection-enable bit.

Reads start at the given address and keep streaming bytes for as long as chip select stays low. Writes collect up to one page in a local buffer. The address wraps inside that page. The buffer is committed when chip select rises, which starts an emulated programming period of `PROG_CYCLES` system clocks. The SPI pins are sampled into the system clock domain, so SCK must run at no more than one eighth of the system clock. The four SPI pins are the only data path. The host paces every bit, so the block has no valid/ready stream and cannot apply back-pressure. A host that needs to wait polls the busy flag.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00. MISO is held at 0 whenever chip select is high.
- R2: Instruction 0x06 sets the write-enable latch and 0x04 clears it.
- R3: Instruction 0x05 returns the status byte on every following byte of the frame. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protection level, bit 7 is the protection-enable bit, and bits 6:4 read 0.
- R4: Instruction 0x03 takes an address of `ADDR_BYTES` bytes, most significant byte first. It then returns the byte at that address and each following address, crossing page boundaries while chip select stays low.
- R5: Instruction 0x02 (data write) or 0x01 (status write) received while the write-enable latch is clear changes neither memory nor status.
- R6: A data write is committed only when chip select rises. The status busy bit is then 1 for exactly `PROG_CYCLES` system clocks.
- R7: Data bytes of one write frame go to consecutive addresses, wrapping from the last byte of a page to the first byte of the same page.
- R8: The write-enable latch clears when a programming period ends.
- R9: While busy, every instruction except 0x05 is ignored.
- R10: Protection level 1 blocks the top quarter of memory, level 2 the top half and level 3 all of it. A data write to a blocked page is dropped: no busy period, the latch stays set, and memory is unchanged.
- R11: Instruction 0x01 followed by one byte loads bit 7 and bits 3:2 of that byte into the status byte when chip select rises, and starts a programming period.
- R12: MOSI is sampled on rising SCK. MISO changes only after falling SCK, so each returned byte is valid on the rising edges of the byte that follows the byte that requested it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |

## Verification
The hardest situation to reach from the pins is a host frame that arrives while a programming period is still running. The status read and the ignored instruction must both fit inside the busy window. The bench keeps `PROG_CYCLES` long compared with one SPI frame. It issues a status read and a clear-latch instruction directly after a write frame, so it sees busy still set and the latch unchanged. Page wrap is reached by starting a four-byte write two bytes before a page end. Protection is reached by writing the status byte first and then aiming a write into the blocked region.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_STAT
  } ee_state_t;
endpackage

// File: rtl/eeprom_spi_phy.sv
module eeprom_spi_phy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       cs_active,
  output logic       miso
);
  logic [2:0] sck_s, cs_s;
  logic [1:0] mosi_s;
  logic [6:0] shreg;
  logic [2:0] bcnt;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 3'b000;
      cs_s   <= 3'b111;
      mosi_s <= 2'b00;
    end else begin
      sck_s  <= {sck_s[1:0], sck};
      cs_s   <= {cs_s[1:0], cs_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  assign cs_active   = ~cs_s[1];
  assign frame_start = ~cs_s[1] & cs_s[2];
  assign frame_end   = cs_s[1] & ~cs_s[2];
  assign sck_rise    = sck_s[1] & ~sck_s[2] & cs_active;
  assign sck_fall    = ~sck_s[1] & sck_s[2] & cs_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bcnt       <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      miso       <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (!cs_active) begin
        bcnt <= '0;
        miso <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg <= {shreg[5:0], mosi_s[1]};
          bcnt  <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            byte_valid <= 1'b1;
            byte_data  <= {shreg, mosi_s[1]};
          end
        end
        if (sck_fall) miso <= tx_byte[3'd7 - bcnt];
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int MEM_DEPTH   = 512,
  parameter int PAGE_SIZE   = 16,
  parameter int PROG_CYCLES = 400,
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int PW = $clog2(PAGE_SIZE),
  localparam int XW = 8 * ADDR_BYTES,
  localparam int CW = $clog2(ADDR_BYTES + 1),
  localparam int TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [7:0]    status
);
  localparam logic [AW:0] LIM_HALF = (AW+1)'(MEM_DEPTH / 2);
  localparam logic [AW:0] LIM_QTR  = (AW+1)'(MEM_DEPTH * 3 / 4);

  ee_state_t        state;
  logic             is_wr, busy, wel, wpen, committing, sr_got;
  logic [1:0]       bp, sr_bp;
  logic             sr_wpen;
  logic [CW-1:0]    acnt;
  logic [XW-1:0]    addr_sh, addr_full_next;
  logic [AW-1:0]    addr_q, addr_next;
  logic [AW-PW-1:0] wr_page;
  logic [PW-1:0]    woff, cidx;
  logic [TW-1:0]    timer;
  logic [7:0]       pbuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] pmask;
  logic [AW:0]      page_base;
  logic             page_blocked;

  assign status         = {wpen, 3'b000, bp, wel, busy};
  assign addr_full_next = (addr_sh << 8) | XW'(byte_data);
  assign addr_next      = AW'(addr_full_next);
  assign rd_addr        = (state == ST_ADDR) ? addr_next : addr_q;
  assign page_base      = {1'b0, wr_page, {PW{1'b0}}};
  assign page_blocked   = (bp == 2'd3) || (bp == 2'd2 && page_base >= LIM_HALF)
                       || (bp == 2'd1 && page_base >= LIM_QTR);
  assign wr_en   = committing & pmask[cidx];
  assign wr_addr = {wr_page, cidx};
  assign wr_data = pbuf[cidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  is_wr <= 1'b0;   busy <= 1'b0;  wel <= 1'b0;
      wpen <= 1'b0;      bp <= 2'b00;     committing <= 1'b0;
      sr_got <= 1'b0;    sr_bp <= 2'b00;  sr_wpen <= 1'b0;
      acnt <= '0;        addr_sh <= '0;   addr_q <= '0;  wr_page <= '0;
      woff <= '0;        cidx <= '0;      timer <= '0;   pmask <= '0;
      tx_byte <= '0;
    end else begin
      if (busy) begin
        if (timer == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          pmask <= '0;
        end else timer <= timer - TW'(1);
        if (committing) begin
          if (cidx == PW'(PAGE_SIZE - 1)) committing <= 1'b0;
          cidx <= cidx + PW'(1);
        end
      end
      if (frame_start) begin
        state   <= ST_OPC;
        acnt    <= '0;
        sr_got  <= 1'b0;
        tx_byte <= '0;
      end else if (frame_end) begin
        state <= ST_IDLE;
        if (state == ST_WDAT && |pmask && !page_blocked) begin
          busy <= 1'b1;  timer <= TW'(PROG_CYCLES - 1);
          committing <= 1'b1;  cidx <= '0;
        end
        if (sr_got) begin
          wpen <= sr_wpen;  bp <= sr_bp;
          busy <= 1'b1;     timer <= TW'(PROG_CYCLES - 1);
        end
      end else if (byte_valid) begin
        case (state)
          ST_OPC: begin
            state <= ST_IDLE;
            if (!busy || byte_data == OP_RDSR) begin
              case (byte_data)
                OP_WREN: wel <= 1'b1;
                OP_WRDI: wel <= 1'b0;
                OP_RDSR: begin tx_byte <= status; state <= ST_STAT; end
                OP_WRSR: if (wel) state <= ST_SRD;
                OP_READ: begin is_wr <= 1'b0; state <= ST_ADDR; end
                OP_WRIT: if (wel) begin
                  is_wr <= 1'b1; pmask <= '0; state <= ST_ADDR;
                end
                default: state <= ST_IDLE;
              endcase
            end
          end
          ST_ADDR: begin
            addr_sh <= addr_full_next;
            acnt    <= acnt + CW'(1);
            if (acnt == CW'(ADDR_BYTES - 1)) begin
              if (is_wr) begin
                wr_page <= addr_next[AW-1:PW];
                woff    <= addr_next[PW-1:0];
                state   <= ST_WDAT;
              end else begin
                tx_byte <= rd_data;
                addr_q  <= addr_next + AW'(1);
                state   <= ST_RDAT;
              end
            end
          end
          ST_RDAT: begin
            tx_byte <= rd_data;
            addr_q  <= addr_q + AW'(1);
          end
          ST_WDAT: begin
            pbuf[woff]  <= byte_data;
            pmask[woff] <= 1'b1;
            woff        <= woff + PW'(1);
          end
          ST_SRD: begin
            sr_wpen <= byte_data[7];
            sr_bp   <= byte_data[3:2];
            sr_got  <= 1'b1;
            state   <= ST_IDLE;
          end
          ST_STAT: tx_byte <= status;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
  parameter int ADDR_BYTES  = 2,
  parameter int MEM_DEPTH   = 512,
  parameter int PAGE_SIZE   = 16,
  parameter int PROG_CYCLES = 400,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic          frame_start, frame_end, byte_valid, cs_active, mem_we;
  logic [7:0]    byte_data, tx_byte, mem_rd, mem_wd, status;
  logic [AW-1:0] mem_ra, mem_wa;

  eeprom_spi_phy u_phy (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .frame_start(frame_start), .frame_end(frame_end),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_active(cs_active), .miso(miso)
  );

  eeprom_cmd_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .MEM_DEPTH(MEM_DEPTH),
    .PAGE_SIZE(PAGE_SIZE), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .byte_valid(byte_valid), .byte_data(byte_data), .tx_byte(tx_byte),
    .rd_addr(mem_ra), .rd_data(mem_rd), .wr_en(mem_we), .wr_addr(mem_wa),
    .wr_data(mem_wd), .status(status)
  );

  eeprom_array #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(mem_ra), .rdata(mem_rd)
  );
endmodule

// File: rtl/spi_eeprom_model_chk.sv
module spi_eeprom_model_chk #(
  parameter int MEM_DEPTH   = 512,
  parameter int PROG_CYCLES = 400,
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int NW = $clog2(PROG_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_active,
  input logic          miso,
  input logic [7:0]    status,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  localparam logic [AW:0] CHK_HALF = (AW+1)'(MEM_DEPTH / 2);
  localparam logic [AW:0] CHK_QTR  = (AW+1)'(MEM_DEPTH * 3 / 4);

  logic [NW-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (status[0]) busy_run <= busy_run + NW'(1);
    else busy_run <= '0;
  end

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && $past(!cs_active)) |-> !miso);

  // R3
  status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> busy_run == NW'(PROG_CYCLES));

  // R6
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> status[0]);

  // R8
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  // R10
  protected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !(status[3:2] == 2'd3
             || (status[3:2] == 2'd2 && {1'b0, wr_addr} >= CHK_HALF)
             || (status[3:2] == 2'd1 && {1'b0, wr_addr} >= CHK_QTR)));
endmodule

bind spi_eeprom_model spi_eeprom_model_chk #(
  .MEM_DEPTH(MEM_DEPTH), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .miso(miso),
  .status(status), .wr_en(mem_we), .wr_addr(mem_wa)
);

// File: tb/spi_eeprom_model_bench.sv
`timescale 1ns/1ps
module spi_eeprom_model_bench;
  localparam time HALF = 100ns;
  localparam time GAP  = 200ns;
  // {addr[15:0], data[7:0]}
  localparam logic [23:0] VEC [6] = '{24'h00A55A, 24'h01A5C3, 24'h002077,
                                      24'h01C09E, 24'h001331, 24'h0100E4};

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  spi_eeprom_model u_spi_eeprom_model (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #10ns clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R12: drive MOSI before rising SCK, sample MISO just before rising SCK
  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      #HALF;
      r[i] = miso;
      sck = 1'b1;
      #HALF;
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo; cs_n = 1'b0; #HALF; endtask
  task automatic cs_hi; #HALF; cs_n = 1'b1; #GAP; endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xbyte(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xbyte(8'h01, d); xbyte(v, d); cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] dat [4], input int n);
    logic [7:0] d;
    cs_lo(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(dat[i], d);
    cs_hi();
  endtask

  task automatic rd(input logic [15:0] a, input int n, output logic [7:0] q [4]);
    logic [7:0] d;
    cs_lo(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, q[i]);
    cs_hi();
  endtask

  task automatic wait_ready;
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
    chk("R6 busy never cleared", s, 8'h00);
  endtask

  initial begin
    #3ms;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [7:0] q [4];
    logic [7:0] w [4];
    repeat (3) @(posedge clk);
    #3ns;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3ns;

    // R1 reset state
    chk("R1 miso idle", {7'd0, miso}, 8'h00);
    rdsr(s); chk("R1 status after reset", s, 8'h00);

    // R2 latch set / clear
    cmd1(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R2 latch clear", s, 8'h00);

    // R4 R6 vector table: single-byte write then read back
    foreach (VEC[i]) begin
      cmd1(8'h06);
      w[0] = VEC[i][7:0];
      wr(VEC[i][23:8], w, 1);
      wait_ready();
      rd(VEC[i][23:8], 1, q);
      chk("R4 table readback", q[0], VEC[i][7:0]);
    end

    // R5 write and status write without latch are ignored
    w[0] = 8'h11;
    wr(16'h00A5, w, 1);
    rdsr(s); chk("R5 no busy without latch", s, 8'h00);
    rd(16'h00A5, 1, q); chk("R5 memory unchanged", q[0], 8'h5A);
    wrsr(8'h8C);
    rdsr(s); chk("R5 status write ignored", s, 8'h00);

    // R7 page wrap, R6 busy, R9 ignore while busy, R8 latch clear
    cmd1(8'h06);
    w = '{8'hAA, 8'hBB, 8'hCC, 8'hDD};
    wr(16'h001E, w, 4);
    rdsr(s); chk("R6 busy after commit", s, 8'h03);
    cmd1(8'h04);
    rdsr(s); chk("R9 clear ignored while busy", s, 8'h03);
    wait_ready();
    rdsr(s); chk("R8 latch cleared after cycle", s, 8'h00);
    rd(16'h001E, 3, q);
    chk("R7 byte at 0x1E", q[0], 8'hAA);
    chk("R7 byte at 0x1F", q[1], 8'hBB);
    chk("R4 R7 next page untouched", q[2], 8'h77);
    rd(16'h0010, 2, q);
    chk("R7 wrapped to 0x10", q[0], 8'hCC);
    chk("R7 wrapped to 0x11", q[1], 8'hDD);
    rd(16'h0013, 1, q); chk("R7 rest of page kept", q[0], 8'h31);

    // R11 status write, R10 protection
    cmd1(8'h06); wrsr(8'h04); wait_ready();
    rdsr(s); chk("R11 level 1 stored", s, 8'h04);
    cmd1(8'h06);
    w[0] = 8'h00;
    wr(16'h01C0, w, 1);
    rdsr(s); chk("R10 blocked write no busy", s, 8'h06);
    rd(16'h01C0, 1, q); chk("R10 blocked byte kept", q[0], 8'h9E);
    w[0] = 8'h4B;
    wr(16'h0100, w, 1);
    wait_ready();
    rd(16'h0100, 1, q); chk("R10 open region written", q[0], 8'h4B);
    cmd1(8'h06); wrsr(8'h8C); wait_ready();
    rdsr(s); chk("R11 enable and level 3", s, 8'h8C);
    cmd1(8'h06);
    w[0] = 8'h00;
    wr(16'h0013, w, 1);
    rdsr(s); chk("R10 level 3 no busy", s, 8'h8E);
    rd(16'h0013, 1, q); chk("R10 level 3 byte kept", q[0], 8'h31);
    wrsr(8'h00); wait_ready();
    rdsr(s); chk("R11 cleared again", s, 8'h00);
    chk("R1 miso idle at end", {7'd0, miso}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule